// File: doc/BRIEF.md
# SHA-512 Message-Schedule Sigma0 Execution Unit

This unit is one SIMD execution slice. It takes one 32-bit instruction word and checks it against a fixed opcode pattern. It then performs the first half of a SHA-512 message-schedule update on two 64-bit lanes at once. Each instruction carries two 128-bit operands. The first is an accumulator, which is also the destination. The second is an extra source. The unit returns a 128-bit value for the register file to write back to the destination index named in the instruction word.

The two result lanes take their inputs crosswise:

- **Low lane:** adds sigma0 of the accumulator's high lane to the accumulator's low lane.
- **High lane:** adds sigma0 of the extra source's low lane to the accumulator's high lane.

The unit raises an undefined-instruction flag and suppresses write-back in two cases:

- the word does not match the opcode pattern;
- the feature-enable input is low.

The datapath has two pipeline stages:

- **Stage 1:** decodes the word and computes both sigma0 values.
- **Stage 2:** performs the two 64-bit additions and registers the result.

A valid/ready handshake sits on each side. The latency from acceptance to result is always two cycles when the output is not stalled, whatever the operand values.

Top module: `sha512_sched_sig0_unit`

## Requirements
- R1: sigma0(v) on a 64-bit value is (v rotated right 1) XOR (v rotated right 8) XOR (v shifted right 7 with zero fill). Result bits 63:0 equal accumulator bits 63:0 plus sigma0(accumulator bits 127:64), modulo 2^64.
- R2: Result bits 127:64 equal accumulator bits 127:64 plus sigma0(source bits 63:0), modulo 2^64. Source bits 127:64 have no effect on the result.
- R3: A word is recognised when its bits 31:10 equal 1100111011000000100000. Bits 4:0 give the destination index, which appears on `out_rd` with the result. Bits 9:5 name the second source register.
- R4: When `feat_en` is low at acceptance, the result carries `out_undef`=1 and `out_wr_en`=0, and `out_result` is zero.
- R5: When bits 31:10 differ from the pattern, the result carries `out_undef`=1 and `out_wr_en`=0, and `out_result` is zero. A recognised word with `feat_en` high gives `out_undef`=0 and `out_wr_en`=1.
- R6: With `out_ready` held high, `out_valid` rises exactly two rising edges after the accepting edge. After the first of those edges it is still low. This holds for every operand value.
- R7: While `out_valid` is high and `out_ready` is low, `out_result`, `out_rd` and `out_undef` hold their values and `out_valid` stays high.
- R8: `in_ready` is low only when stage 1 is occupied and the output stage is full and not being drained. Otherwise it is high.
- R9: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands offered |
| in_ready | output | 1 | Unit can accept an instruction this cycle |
| insn | input | 32 | Instruction word |
| feat_en | input | 1 | Feature enable; low makes the instruction undefined |
| opd_acc | input | 128 | Accumulator/destination operand |
| opd_src | input | 128 | Second source operand |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 128 | Write-back value (zero when undefined) |
| out_rd | output | 5 | Destination register index |
| out_undef | output | 1 | Undefined-instruction flag |
| out_wr_en | output | 1 | Write-back enable |

## Verification
The bench builds the unit with its default parameters:

- 64-bit lanes;
- the standard rotate amounts of 1 and 8 and the shift of 7;
- the 22-bit opcode pattern.

This exercises the real SHA-512 sigma0 and the real decode pattern. Under these values, lanes with only bit 63 set, only bit 0 set, all ones or all zeros hit the wrap-around of both rotations, the zero fill of the shift, and the carry out of each 64-bit addition. A separate stalled sequence fills both pipeline stages, which brings the input back-pressure and the output hold into view.

// File: rtl/sha512_s0_pkg.sv
`timescale 1ns/1ps
package sha512_s0_pkg;
  localparam int LANE_W = 64;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  typedef logic [LANE_W-1:0] lane_t;

  // Rotate right by n (0 < n < LANE_W)
  function automatic lane_t lane_ror(lane_t v, int unsigned n);
    return (v >> n) | (v << (LANE_W - n));
  endfunction

  function automatic lane_t lane_sigma(lane_t v, int unsigned ra, int unsigned rb,
                                       int unsigned sh);
    return lane_ror(v, ra) ^ lane_ror(v, rb) ^ (v >> sh);
  endfunction

  // Modular lane addition; the carry out of the top bit is discarded
  function automatic lane_t lane_add(lane_t a, lane_t b);
    return a + b;
  endfunction
endpackage

// File: rtl/s0_decode.sv
`timescale 1ns/1ps
module s0_decode #(
  parameter int INSN_W = 32,
  parameter int IDX_W  = 5,
  parameter int OPC_LO = 10,
  parameter logic [INSN_W-OPC_LO-1:0] OPCODE = 22'b1100111011000000100000
) (
  input  logic [INSN_W-1:0] insn,
  input  logic              feat_en,
  output logic [IDX_W-1:0]  dec_rd,
  output logic [IDX_W-1:0]  dec_rn,
  output logic              dec_match,
  output logic              dec_undef
);
  assign dec_match = (insn[INSN_W-1:OPC_LO] == OPCODE);
  assign dec_rd    = insn[IDX_W-1:0];
  assign dec_rn    = insn[2*IDX_W-1:IDX_W];
  assign dec_undef = !dec_match || !feat_en;
endmodule

// File: rtl/s0_sigma.sv
`timescale 1ns/1ps
module s0_sigma
  import sha512_s0_pkg::*;
#(
  parameter int unsigned ROT_A = 1,
  parameter int unsigned ROT_B = 8,
  parameter int unsigned SHR_C = 7
) (
  input  lane_t v,
  output lane_t s
);
  assign s = lane_sigma(v, ROT_A, ROT_B, SHR_C);
endmodule

// File: rtl/s0_lane_add.sv
`timescale 1ns/1ps
module s0_lane_add
  import sha512_s0_pkg::*;
(
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] incr,
  output logic [DATA_W-1:0] sum
);
  for (genvar g = 0; g < LANES; g++) begin : g_add
    assign sum[g*LANE_W +: LANE_W] = lane_add(base[g*LANE_W +: LANE_W],
                                              incr[g*LANE_W +: LANE_W]);
  end
endmodule

// File: rtl/sha512_sched_sig0_unit.sv
`timescale 1ns/1ps
module sha512_sched_sig0_unit
  import sha512_s0_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int IDX_W  = 5,
  parameter int OPC_LO = 10,
  parameter logic [INSN_W-OPC_LO-1:0] OPCODE = 22'b1100111011000000100000,
  parameter int unsigned ROT_A = 1,
  parameter int unsigned ROT_B = 8,
  parameter int unsigned SHR_C = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] insn,
  input  logic              feat_en,
  input  logic [DATA_W-1:0] opd_acc,
  input  logic [DATA_W-1:0] opd_src,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [IDX_W-1:0]  out_rd,
  output logic              out_undef,
  output logic              out_wr_en
);
  // Handshake events brought out as named wires
  logic in_fire, s2_take, s1_adv;
  logic s1_valid, s1_undef;
  logic [IDX_W-1:0]  s1_rd;
  logic [DATA_W-1:0] s1_sig, s1_base;

  assign s2_take  = !out_valid || out_ready;
  assign s1_adv   = s1_valid && s2_take;
  assign in_ready = !s1_valid || s2_take;
  assign in_fire  = in_valid && in_ready;

  // Decode
  logic [IDX_W-1:0] dec_rd, dec_rn;
  logic dec_match, dec_undef;

  s0_decode #(.INSN_W(INSN_W), .IDX_W(IDX_W), .OPC_LO(OPC_LO), .OPCODE(OPCODE)) u_dec (
    .insn(insn), .feat_en(feat_en), .dec_rd(dec_rd), .dec_rn(dec_rn),
    .dec_match(dec_match), .dec_undef(dec_undef)
  );

  // The operand values arrive already read; the source index is not needed here
  logic unused_rn, unused_src_hi, unused_match;
  assign unused_rn     = ^dec_rn;
  assign unused_match  = dec_match;
  assign unused_src_hi = ^opd_src[DATA_W-1:LANE_W];

  // Stage 1: sigma0 per lane, cross-connected inputs
  logic [DATA_W-1:0] sig_next;
  for (genvar g = 0; g < LANES; g++) begin : g_sig
    lane_t opnd;
    if (g == 0) begin : g_lo
      assign opnd = opd_acc[DATA_W-1:LANE_W];   // low result uses accumulator high lane
    end else begin : g_hi
      assign opnd = opd_src[LANE_W-1:0];        // high result uses source low lane
    end
    s0_sigma #(.ROT_A(ROT_A), .ROT_B(ROT_B), .SHR_C(SHR_C)) u_sig (
      .v(opnd), .s(sig_next[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_undef <= 1'b0;
      s1_rd    <= '0;
      s1_sig   <= '0;
      s1_base  <= '0;
    end else begin
      if (in_fire) begin
        s1_valid <= 1'b1;
        s1_undef <= dec_undef;
        s1_rd    <= dec_rd;
        s1_sig   <= sig_next;
        s1_base  <= opd_acc;
      end else if (s1_adv) begin
        s1_valid <= 1'b0;
      end
    end
  end

  // Stage 2: lane additions and output register
  logic [DATA_W-1:0] sum;
  s0_lane_add u_add (.base(s1_base), .incr(s1_sig), .sum(sum));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_undef  <= 1'b0;
      out_rd     <= '0;
      out_result <= '0;
    end else if (s2_take) begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_undef  <= s1_undef;
        out_rd     <= s1_rd;
        out_result <= s1_undef ? '0 : sum;
      end
    end
  end

  assign out_wr_en = out_valid && !out_undef;

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_rd)
                                && $stable(out_undef));
  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && out_valid && !out_ready |-> !in_ready);
  // R6
  s1_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> s1_valid);
  // R6
  s2_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && s2_take |=> out_valid);
  // R4
  undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_undef |-> !out_wr_en && out_result == '0);
  // R4
  feat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && !feat_en |=> s1_undef);
  // R9
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/test_sha512_sched_sig0_unit.sv
`timescale 1ns/1ps
module test_sha512_sched_sig0_unit;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, feat_en = 1, out_ready = 1;
  logic [31:0] insn = '0;
  logic [127:0] opd_acc = '0, opd_src = '0;
  logic in_ready, out_valid, out_undef, out_wr_en;
  logic [127:0] out_result;
  logic [4:0] out_rd;
  int total = 0, bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  sha512_sched_sig0_unit i_sha512_sched_sig0_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .insn(insn),
    .feat_en(feat_en), .opd_acc(opd_acc), .opd_src(opd_src), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_rd(out_rd),
    .out_undef(out_undef), .out_wr_en(out_wr_en)
  );

  localparam logic [21:0] PAT = 22'b1100111011000000100000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] B63  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] B0   = 64'h0000_0000_0000_0001;
  localparam int NV = 8;
  localparam logic [127:0] VA [NV] = '{
    {64'd0, 64'd0}, {ONES, ONES}, {B63, 64'd0}, {B0, 64'd0},
    {64'd0, ONES}, {B63, B0}, {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210}, {ONES, B63}};
  localparam logic [127:0] VS [NV] = '{
    {64'd0, 64'd0}, {ONES, ONES}, {64'd0, B63}, {64'd0, B0},
    {ONES, 64'd0}, {B0, B63}, {64'h1111_2222_3333_4444, 64'hDEAD_BEEF_CAFE_F00D}, {ONES, ONES}};

  // Bench model: rotations written as concatenations
  function automatic logic [63:0] bsig(logic [63:0] v);
    return {v[0], v[63:1]} ^ {v[7:0], v[63:8]} ^ {7'b0, v[63:7]};
  endfunction
  function automatic logic [127:0] bref(logic [127:0] a, logic [127:0] s);
    logic [63:0] lo, hi;
    lo = a[63:0] + bsig(a[127:64]);
    hi = a[127:64] + bsig(s[63:0]);
    return {hi, lo};
  endfunction
  function automatic logic [31:0] mk(logic [4:0] rn, logic [4:0] rd);
    return {PAT, rn, rd};
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // One transaction with out_ready high; checks the latency and the outputs
  task automatic run_op(logic [31:0] w, logic fe, logic [127:0] a, logic [127:0] s,
                        logic undef_exp, string req);
    @(negedge clk);
    insn = w; feat_en = fe; opd_acc = a; opd_src = s; in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk("R6 first edge", {127'd0, out_valid}, 128'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R6 second edge", {127'd0, out_valid}, 128'd1);
    chk({req, " result"}, out_result, undef_exp ? 128'd0 : bref(a, s));
    chk("R3 rd", {123'd0, out_rd}, {123'd0, w[4:0]});
    chk("R4/R5 undef", {126'd0, out_undef, out_wr_en}, undef_exp ? 128'd2 : 128'd1);
  endtask

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset state", {126'd0, out_valid, in_ready}, 128'd1);

    // Table of directed edge vectors: R1 low lane, R2 high lane
    for (int i = 0; i < NV; i++)
      run_op(mk(5'(i), 5'(31 - i)), 1'b1, VA[i], VS[i], 1'b0, "R1 R2 table");

    // Hand-computed: all-ones accumulator, sigma0(ones)=01FF..FF, sum wraps
    run_op(mk(5'd1, 5'd2), 1'b1, {ONES, ONES}, 128'd0, 1'b0, "R1 wrap");
    chk("R1 hand value", out_result[63:0], {64'h01FF_FFFF_FFFF_FFFE});

    // R2: source high lane has no effect
    run_op(mk(5'd3, 5'd4), 1'b1, {B0, B63}, {ONES, 64'd5}, 1'b0, "R2 src-hi ignored");
    chk("R2 src-hi ignored", out_result, bref({B0, B63}, {64'd0, 64'd5}));

    // R4: feature disabled
    run_op(mk(5'd7, 5'd9), 1'b0, {ONES, B0}, {B63, ONES}, 1'b1, "R4 feature off");
    // R5: mismatched pattern (flip bit 20 / bit 10)
    run_op(mk(5'd7, 5'd9) ^ 32'h0010_0000, 1'b1, {ONES, B0}, {B63, ONES}, 1'b1, "R5 bad opcode");
    run_op(mk(5'd0, 5'd1) ^ 32'h0000_0400, 1'b1, {B0, B0}, {B0, B0}, 1'b1, "R5 bad opcode low bit");

    // Random operands, fixed latency for every value (R6)
    for (int i = 0; i < 40; i++)
      run_op(mk(5'($urandom), 5'($urandom)), 1'b1,
             {$urandom, $urandom, $urandom, $urandom},
             {$urandom, $urandom, $urandom, $urandom}, 1'b0, "R1 R2 random");

    // Stall: fill both stages with out_ready low (R7, R8)
    @(negedge clk);
    out_ready = 0;
    insn = mk(5'd1, 5'd11); feat_en = 1; opd_acc = VA[6]; opd_src = VS[6]; in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    insn = mk(5'd2, 5'd12); opd_acc = VA[5]; opd_src = VS[5];
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk("R8 in_ready low when full", {127'd0, in_ready}, 128'd0);
    chk("R7 first result", out_result, bref(VA[6], VS[6]));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 held result", out_result, bref(VA[6], VS[6]));
    chk("R7 held rd/valid", {122'd0, out_valid, out_rd}, {122'd0, 1'b1, 5'd11});
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R8 in_ready back", {127'd0, in_ready}, 128'd1);
    chk("R7 second result", {out_result}, bref(VA[5], VS[5]));
    chk("R3 second rd", {123'd0, out_rd}, 128'd12);
    @(posedge clk);
    @(negedge clk);
    chk("R6 drained", {127'd0, out_valid}, 128'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule